// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block steps through the addresses of one DMA work unit, one element at a time. A descriptor loader programs it with a start address, an X (inner) count and signed stride, a Y (outer) count and signed stride, and a few mode flags, then pulses `start_i`. After that, each element the data mover hands over on the element handshake moves the current address by the X stride and counts X down. At the end of a row in 2D mode the X count is reloaded, Y counts down, and the address jumps by the Y stride. The jump is measured from the row's last element, so the final X step of the row has no effect.

When the last row ends there are two outcomes. In stop flow the channel stops and raises a done flag. In chained flow it pulses a descriptor request, then waits with the handshake closed until the loader pulses `start_i` again. An optional per-row interrupt pulse marks every row end. The data path and the descriptor fetch are outside this block.

The element handshake follows valid/ready rules. The mover raises `elem_valid_i` and may hold it for any length of time. An element is consumed at a rising edge where both `elem_valid_i` and `elem_ready_o` are high. `elem_ready_o` is the only source of back-pressure. It is low whenever the channel is not actively sequencing, so any valid offered then is ignored.

Top module: `dma2d_addr_gen`

## Requirements
- R1: A `start_i` pulse while `chan_en_i` is high does the following at the next edge: loads the current address from `start_addr_i`, loads the current X and Y counts from `x_count_i` and `y_count_i` (a programmed 0 loads as 0xFFFF), clears `done_o` and sets `running_o`. A `start_i` pulse while `chan_en_i` is low has no effect.
- R2: `elem_ready_o` is high only while the channel is actively sequencing, `chan_en_i` is high and `start_i` is low. A valid offered without ready leaves the address and the counts unchanged.
- R3: An accepted element that is not the last of its row adds the sign-extended 16-bit two's-complement `x_mod_i` to the address and decrements the X count by one.
- R4: In 2D mode (`mode_2d_i`=1), accepting the last element of a row while the Y count is above 1 does three things: the address becomes the previous address plus the sign-extended `y_mod_i`, the X count reloads with the programmed X count, and Y decrements by one.
- R5: Each accepted row-ending element produces a one-cycle `row_irq_o` pulse in the following cycle when the interrupt enable was set at start, and no pulse otherwise.
- R6: In stop flow (`stop_flow_i`=1), accepting the final element of the last row adds the X stride to the address and sets X to 0. In the next cycle `running_o` is 0 and `done_o` is 1, and `done_o` stays set until the next start.
- R7: In chained flow (`stop_flow_i`=0), the final element of the last row produces a one-cycle `desc_req_o` pulse. The channel then stays running with `elem_ready_o` low until the next start.
- R8: Outside 2D mode the Y count is ignored and stays as loaded, and a single row ends the work unit.
- R9: Address arithmetic wraps modulo 2^32 for both positive and negative strides.
- R10: Dropping `chan_en_i` stops the sequence at the next edge: `running_o` goes to 0, `done_o` keeps its value, and elements are refused until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 1 | Channel enable |
| start_i | input | 1 | Load the programmed values and begin a work unit |
| start_addr_i | input | 32 | Start address of the work unit |
| x_count_i | input | 16 | Elements per row (0 means 0xFFFF) |
| x_mod_i | input | 16 | Signed stride between elements |
| y_count_i | input | 16 | Rows per work unit in 2D mode (0 means 0xFFFF) |
| y_mod_i | input | 16 | Signed stride from a row's last element to the next row |
| mode_2d_i | input | 1 | Enable 2D sequencing |
| stop_flow_i | input | 1 | 1: stop when done; 0: request next descriptor |
| int_en_i | input | 1 | Per-row interrupt enable |
| elem_valid_i | input | 1 | Data mover offers an element |
| elem_ready_o | output | 1 | Channel accepts an element |
| cur_addr_o | output | 32 | Current element address |
| cur_x_o | output | 16 | Current X count |
| cur_y_o | output | 16 | Current Y count |
| running_o | output | 1 | Channel running (sequencing or awaiting a descriptor) |
| done_o | output | 1 | Work unit finished in stop flow |
| row_irq_o | output | 1 | One-cycle per-row interrupt pulse |
| desc_req_o | output | 1 | One-cycle request to load the next descriptor |

## Verification
The hardest case to reach is a row boundary that lands on the address wrap at the same time as a negative Y stride. The same goes for a chained completion that meets a valid which is still held high while the channel waits for its descriptor. The stimulus gets there with short rows (two to four elements), strides chosen so the row jumps go backwards, start addresses near 0 and near 2^32, and a valid held high across the `desc_req_o` cycle. A behavioural model in the bench advances on every edge, and every output is compared against it in every cycle, so each boundary is checked in the exact cycle where it happens.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_ACTIVE    = 2'd1,
    SEQ_WAIT_DESC = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic step_x;    // move by X stride, count X down
    logic row_turn;  // 2D row change: reload X, count Y down, Y jump
    logic fin_stop;  // last element, stop flow
    logic fin_chain; // last element, chained flow
  } seq_action_t;

endpackage

// File: rtl/dma2d_count_unit.sv
module dma2d_count_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= (load_val == '0) ? FULL : load_val;
    else if (dec)     cnt <= cnt - ONE;
  end

  // R1: a load never leaves a zero count behind
  assert_load_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt != '0);

  // R3: a decrement removes exactly one
  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/dma2d_addr_unit.sv
module dma2d_addr_unit #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step_x,
  input  logic          step_y,
  input  logic [MW-1:0] x_mod,
  input  logic [MW-1:0] y_mod,
  output logic [AW-1:0] addr
);
  localparam int PADW = AW - MW;

  logic [AW-1:0] x_ext, y_ext, addr_nx;

  assign x_ext = {{PADW{x_mod[MW-1]}}, x_mod};
  assign y_ext = {{PADW{y_mod[MW-1]}}, y_mod};

  always_comb begin
    addr_nx = addr;
    if (load)        addr_nx = load_addr;
    else if (step_y) addr_nx = addr + y_ext;
    else if (step_x) addr_nx = addr + x_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_nx;
  end

  // R4: the two stride kinds never apply in the same cycle
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_x && step_y));

endmodule

// File: rtl/dma2d_seq_ctrl.sv
module dma2d_seq_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          start,
  input  logic          elem_valid,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic          mode_2d,
  input  logic          stop_flow,
  input  logic          int_en,
  output logic          elem_ready,
  output logic          start_ok,
  output dma2d_pkg::seq_action_t act,
  output logic          running,
  output logic          done,
  output logic          row_irq,
  output logic          desc_req
);
  import dma2d_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  seq_state_t state, state_nx;
  logic accept, row_end, turn;

  assign start_ok   = chan_en && start;
  assign elem_ready = (state == SEQ_ACTIVE) && chan_en && !start;
  assign accept     = elem_valid && elem_ready;
  assign row_end    = accept && (cur_x == ONE);
  assign turn       = row_end && mode_2d && (cur_y > ONE);

  always_comb begin
    act.step_x    = accept && !turn;
    act.row_turn  = turn;
    act.fin_stop  = row_end && !turn && stop_flow;
    act.fin_chain = row_end && !turn && !stop_flow;
  end

  always_comb begin
    state_nx = state;
    if (!chan_en)           state_nx = SEQ_IDLE;
    else if (start)         state_nx = SEQ_ACTIVE;
    else if (act.fin_stop)  state_nx = SEQ_IDLE;
    else if (act.fin_chain) state_nx = SEQ_WAIT_DESC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      done     <= 1'b0;
      row_irq  <= 1'b0;
      desc_req <= 1'b0;
    end else begin
      state    <= state_nx;
      row_irq  <= row_end && int_en;
      desc_req <= act.fin_chain;
      if (start_ok)          done <= 1'b0;
      else if (act.fin_stop) done <= 1'b1;
    end
  end

  assign running = (state != SEQ_IDLE);

  // R5: an interrupt pulse follows an accepted element with interrupts on
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_irq |-> $past(int_en && elem_valid && elem_ready));

  // R6: a finished channel is never running
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);

  // R7: a descriptor request leaves the channel waiting, handshake closed
  assert_desc_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req |-> (running && !elem_ready));

  // R10: losing the enable stops the sequence at the next edge
  assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !running);

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] x_count_i,
  input  logic [MW-1:0] x_mod_i,
  input  logic [CW-1:0] y_count_i,
  input  logic [MW-1:0] y_mod_i,
  input  logic          mode_2d_i,
  input  logic          stop_flow_i,
  input  logic          int_en_i,
  input  logic          elem_valid_i,
  output logic          elem_ready_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_x_o,
  output logic [CW-1:0] cur_y_o,
  output logic          running_o,
  output logic          done_o,
  output logic          row_irq_o,
  output logic          desc_req_o
);
  import dma2d_pkg::*;

  // programmed values captured at start
  logic [CW-1:0] x_count_q;
  logic [MW-1:0] x_mod_q, y_mod_q;
  logic          mode_2d_q, stop_flow_q, int_en_q;

  logic        start_ok;
  seq_action_t act;
  logic [CW-1:0] x_load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_count_q   <= '0;
      x_mod_q     <= '0;
      y_mod_q     <= '0;
      mode_2d_q   <= 1'b0;
      stop_flow_q <= 1'b0;
      int_en_q    <= 1'b0;
    end else if (start_ok) begin
      x_count_q   <= x_count_i;
      x_mod_q     <= x_mod_i;
      y_mod_q     <= y_mod_i;
      mode_2d_q   <= mode_2d_i;
      stop_flow_q <= stop_flow_i;
      int_en_q    <= int_en_i;
    end
  end

  dma2d_seq_ctrl #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en_i),
    .start      (start_i),
    .elem_valid (elem_valid_i),
    .cur_x      (cur_x_o),
    .cur_y      (cur_y_o),
    .mode_2d    (mode_2d_q),
    .stop_flow  (stop_flow_q),
    .int_en     (int_en_q),
    .elem_ready (elem_ready_o),
    .start_ok   (start_ok),
    .act        (act),
    .running    (running_o),
    .done       (done_o),
    .row_irq    (row_irq_o),
    .desc_req   (desc_req_o)
  );

  assign x_load_val = start_ok ? x_count_i : x_count_q;

  dma2d_count_unit #(.CW(CW)) u_xcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok || act.row_turn),
    .load_val (x_load_val),
    .dec      (act.step_x),
    .cnt      (cur_x_o)
  );

  dma2d_count_unit #(.CW(CW)) u_ycnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (y_count_i),
    .dec      (act.row_turn),
    .cnt      (cur_y_o)
  );

  dma2d_addr_unit #(.AW(AW), .MW(MW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .load_addr (start_addr_i),
    .step_x    (act.step_x),
    .step_y    (act.row_turn),
    .x_mod     (x_mod_q),
    .y_mod     (y_mod_q),
    .addr      (cur_addr_o)
  );

  // R2: ready is only offered by a running channel
  assert_ready_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    elem_ready_o |-> running_o);

  // R2: without a handshake or a start the address holds
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(elem_valid_i && elem_ready_o) && !(start_i && chan_en_i))
      |=> cur_addr_o == $past(cur_addr_o));

  // R8: outside 2D mode the Y count never moves after its load
  assert_y_fixed_1d_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_2d_q && !(start_i && chan_en_i)) |=> cur_y_o == $past(cur_y_o));

endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] x_count = '0, x_mod = '0, y_count = '0, y_mod = '0;
  logic        mode_2d = 1'b0, stop_flow = 1'b0, int_en = 1'b0, elem_valid = 1'b0;
  logic        elem_ready, running, done, row_irq, desc_req;
  logic [31:0] cur_addr;
  logic [15:0] cur_x, cur_y;

  always #2.5 clk = ~clk;

  dma2d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en), .start_i(start),
    .start_addr_i(start_addr), .x_count_i(x_count), .x_mod_i(x_mod),
    .y_count_i(y_count), .y_mod_i(y_mod), .mode_2d_i(mode_2d),
    .stop_flow_i(stop_flow), .int_en_i(int_en), .elem_valid_i(elem_valid),
    .elem_ready_o(elem_ready), .cur_addr_o(cur_addr), .cur_x_o(cur_x),
    .cur_y_o(cur_y), .running_o(running), .done_o(done),
    .row_irq_o(row_irq), .desc_req_o(desc_req)
  );

  // behavioural reference model: 0 idle, 1 sequencing, 2 awaiting descriptor
  int          m_st = 0;
  bit   [31:0] m_addr = 0;
  int          m_x = 0, m_y = 0, m_xc = 0, m_xm = 0, m_ym = 0;
  bit          m_2d = 0, m_stop = 0, m_ie = 0, m_done = 0, m_irq = 0, m_desc = 0;

  int    n_cmp = 0, n_bad = 0;
  string phase_req = "R1";
  bit    finished = 0;
  bit [7:0] lfsr = 8'hA5;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_x = 0; m_y = 0; m_done = 0; m_irq = 0; m_desc = 0;
      m_2d = 0; m_stop = 0; m_ie = 0;
    end else begin
      bit acc;
      acc = chan_en && !start && (m_st == 1) && elem_valid;
      m_irq = 0; m_desc = 0;
      if (!chan_en) m_st = 0;
      else if (start) begin
        m_addr = start_addr;
        m_xc = x_count;
        m_x = (x_count == 0) ? 16'hFFFF : x_count;
        m_y = (y_count == 0) ? 16'hFFFF : y_count;
        m_xm = $signed(x_mod); m_ym = $signed(y_mod);
        m_2d = mode_2d; m_stop = stop_flow; m_ie = int_en;
        m_done = 0; m_st = 1;
      end else if (acc) begin
        if (m_x == 1) begin
          m_irq = m_ie;
          if (m_2d && m_y > 1) begin
            m_addr = m_addr + m_ym;
            m_x = (m_xc == 0) ? 16'hFFFF : m_xc;
            m_y = m_y - 1;
          end else begin
            m_addr = m_addr + m_xm;
            m_x = 0;
            if (m_stop) begin m_done = 1; m_st = 0; end
            else begin m_desc = 1; m_st = 2; end
          end
        end else begin
          m_addr = m_addr + m_xm;
          m_x = m_x - 1;
        end
      end
    end
  end

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("R2", "elem_ready", 32'(elem_ready), 32'((m_st == 1) && chan_en && !start));
      cmp(phase_req, "cur_addr", cur_addr, m_addr);
      cmp(phase_req, "cur_x", 32'(cur_x), 32'(m_x));
      cmp(phase_req, "cur_y", 32'(cur_y), 32'(m_y));
      cmp("R10", "running", 32'(running), 32'(m_st != 0));
      cmp("R6", "done", 32'(done), 32'(m_done));
      cmp("R5", "row_irq", 32'(row_irq), 32'(m_irq));
      cmp("R7", "desc_req", 32'(desc_req), 32'(m_desc));
    end
  end

  task automatic kick(input logic [31:0] a, input logic [15:0] xc, input logic [15:0] xm,
                      input logic [15:0] yc, input logic [15:0] ym,
                      input bit d2, input bit stp, input bit ie);
    @(negedge clk); #1;
    elem_valid = 0;
    start_addr = a; x_count = xc; x_mod = xm; y_count = yc; y_mod = ym;
    mode_2d = d2; stop_flow = stp; int_en = ie; start = 1;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic run_elems(input int maxc, input bit dense);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk); #1;
      if (m_st != 1) break;
      elem_valid = dense ? 1'b1 : (lfsr[0] | lfsr[3]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    elem_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    chan_en = 1;
    idle_cycles(3);
    rst_n = 1;
    idle_cycles(2);

    // R1/R8: 1D stop flow, Y programmed but ignored
    kick(32'h0000_1000, 16'd4, 16'd4, 16'd3, 16'h0010, 0, 1, 1);
    phase_req = "R8";
    run_elems(60, 0);
    idle_cycles(2);

    // R4: 2D stop flow with a backwards row jump
    phase_req = "R1";
    kick(32'h0000_2000, 16'd3, 16'd2, 16'd3, 16'hFFFA, 1, 1, 1);
    phase_req = "R4";
    run_elems(80, 0);
    idle_cycles(2);

    // R7: chained flow, valid held high while waiting for the descriptor
    kick(32'h0000_3000, 16'd2, 16'hFFFE, 16'd1, 16'h0000, 0, 0, 0);
    phase_req = "R3";
    run_elems(40, 1);
    phase_req = "R7";
    elem_valid = 1;
    idle_cycles(5);
    elem_valid = 0;
    kick(32'h0000_4000, 16'd3, 16'd1, 16'd1, 16'd0, 0, 1, 1);
    phase_req = "R3";
    run_elems(40, 1);
    idle_cycles(2);

    // R9: address wrap upward, then downward
    kick(32'hFFFF_FFF8, 16'd4, 16'd4, 16'd1, 16'd0, 0, 1, 0);
    phase_req = "R9";
    run_elems(40, 0);
    kick(32'h0000_0004, 16'd3, 16'hFFF8, 16'd1, 16'd0, 0, 1, 0);
    phase_req = "R9";
    run_elems(40, 1);
    // R9/R4: 2D rows crossing zero with a negative row jump
    kick(32'h0000_0002, 16'd2, 16'd2, 16'd3, 16'hFFF0, 1, 1, 1);
    run_elems(60, 0);
    idle_cycles(2);

    // R10: enable dropped mid-sequence, valid held through it
    kick(32'h0000_5000, 16'd10, 16'd4, 16'd1, 16'd0, 0, 1, 1);
    phase_req = "R10";
    elem_valid = 1;
    idle_cycles(3);
    chan_en = 0;
    idle_cycles(3);
    chan_en = 1;
    phase_req = "R2";
    idle_cycles(3);
    elem_valid = 0;

    // R1: start while disabled is ignored; zero counts load as all-ones
    chan_en = 0;
    phase_req = "R1";
    kick(32'h0000_6000, 16'd5, 16'd1, 16'd5, 16'd0, 0, 1, 0);
    idle_cycles(2);
    chan_en = 1;
    kick(32'h0000_7000, 16'd0, 16'd1, 16'd0, 16'd0, 1, 1, 0);
    run_elems(6, 1);
    chan_en = 0;
    idle_cycles(2);
    chan_en = 1;

    // R5/R4: 2D chained flow with interrupts off
    kick(32'h0000_8000, 16'd2, 16'd8, 16'd2, 16'h0100, 1, 0, 0);
    phase_req = "R5";
    run_elems(40, 0);
    idle_cycles(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule